// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block fetches the station MAC address from a three-wire serial configuration EEPROM. Once reset is released, and again on every `start` pulse taken while idle, it reads the first sixteen 16-bit words of the EEPROM, one read access per word, and fills a 32-byte internal buffer. From that buffer it presents six bytes as a 48-bit address. `busy` is high while a load runs. `done` rises when the load finishes and stays high until the next accepted start.

Each access has the same shape. Chip select is held low for half a shift-clock period. It then goes high and the block shifts out a 9-bit read command, most significant bit first: the bits 1,1,0 followed by the 6-bit word address. Sixteen data bits then come back, also most significant bit first. Chip select drops again at the end of the word. The shift clock runs only during the command and data phases. Its high and low halves each last `HALF_DIV` system clocks. The data-out pin passes through a two-flop synchronizer before it is used.

Top module: `eeprom_mac_loader`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `eeCs`, `eeSk`, `eeDi` and `macAddr` are all zero. A load starts by itself on the first clock after reset is released, so `busy` is high one clock later.
- R2: A `start` pulse sampled while idle begins a load. On the next clock `busy` is 1 and `done` is 0.
- R3: Before each command, chip select stays low for at least `HALF_DIV` clocks. The command is the 9 bits 1,1,0,a5..a0, sent most significant bit first. `eeDi` never changes on a rising shift-clock edge.
- R4: After the command, 16 data bits are read most significant bit first. Each bit is taken at the end of the high half of its shift-clock pulse, that is, the 10th to 25th rising edges of the access.
- R5: One load reads word addresses 0 through 15 in ascending order. Chip select falls once after each word: 16 falls and 16 complete 25-edge accesses per load.
- R6: Word w is stored with its low byte at byte 2w and its high byte at byte 2w+1. `macAddr[47:40]` = byte 20 (the first octet on the wire), down to `macAddr[7:0]` = byte 25. Bytes 20 to 25 are therefore, in order, low(w10), high(w10), low(w11), high(w11), low(w12), high(w12).
- R7: Every high half of the shift clock lasts exactly `HALF_DIV` system clocks.
- R8: `done` and `macAddr` hold their values until the next accepted `start`. `done` and `busy` are never high together.
- R9: A `start` that arrives while `busy` is ignored. The load in progress ends after exactly 16 words with a single rise of `done`, and no further load follows.
- R10: `eeSk` is never high while `eeCs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to reload the address |
| busy | output | 1 | A load is in progress |
| done | output | 1 | The last load completed; `macAddr` is valid |
| macAddr | output | 48 | Station address; bits 47:40 are the first octet |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM shift clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |

## Verification
`busy` responds on the first clock after `start` or after reset is released, so the bench checks it at the first falling edge after its stimulus. `done` and `macAddr` settle only after a full load of 16 accesses, each (2·9 + 2·16 + 2)·`HALF_DIV` clocks long. The bench therefore waits for `done` in a bounded loop rather than counting a fixed number of cycles. It then compares the address with the value its EEPROM model's word pattern predicts. The model changes data-out one clock after a falling shift-clock edge, which leaves the two synchronizer stages a full low half plus a high half before the sampling edge. It checks the command bits and the address order at every rising edge as they arrive.

// File: rtl/macload_pkg.sv
package macload_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] READ_OPC = 3'b110;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_SEL, S_CMDL, S_CMDH, S_DATL, S_DATH, S_STOP
  } seqState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic diEn;
    logic shiftIn;
    logic storeWord;
  } dpStrobe_t;
endpackage

// File: rtl/macload_ctrl.sv
module macload_ctrl
  import macload_pkg::*;
#(
  parameter int HALF_DIV = 64,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int WORDS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              eeCs,
  output logic              eeSk,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int CNT_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CMD_BITS = OPC_W + ADDR_W;
  localparam int MAXBITS  = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
  localparam int BIT_W    = $clog2(MAXBITS + 1);
  localparam int WIDX_W   = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0]  HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0]  CMD_LAST  = BIT_W'(CMD_BITS - 1);
  localparam logic [BIT_W-1:0]  DATA_LAST = BIT_W'(DATA_W - 1);
  localparam logic [WIDX_W-1:0] WORD_END  = WIDX_W'(WORDS);

  seqState_t          state;
  logic [CNT_W-1:0]   halfCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [WIDX_W-1:0]  wordIdx;
  logic               kick;
  logic               tick;
  logic               lastWord;

  assign tick     = (halfCnt == HALF_LAST);
  assign lastWord = (wordIdx == WORD_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (state == S_IDLE || tick) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kick    <= 1'b1;
      done    <= 1'b0;
      wordIdx <= '0;
      bitCnt  <= '0;
    end else begin
      kick <= 1'b0;
      case (state)
        S_IDLE: if (kick || start) begin
          state   <= S_GAP;
          done    <= 1'b0;
          wordIdx <= '0;
        end
        S_GAP:  if (tick) state <= S_SEL;
        S_SEL:  if (tick) begin
          state  <= S_CMDL;
          bitCnt <= '0;
        end
        S_CMDL: if (tick) state <= S_CMDH;
        S_CMDH: if (tick) begin
          if (bitCnt == CMD_LAST) begin
            state  <= S_DATL;
            bitCnt <= '0;
          end else begin
            state  <= S_CMDL;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_DATL: if (tick) state <= S_DATH;
        S_DATH: if (tick) begin
          if (bitCnt == DATA_LAST) begin
            state   <= S_STOP;
            wordIdx <= wordIdx + 1'b1;
          end else begin
            state  <= S_DATL;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          if (lastWord) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= S_SEL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadCmd   = tick && (state == S_GAP || (state == S_STOP && !lastWord));
    strobe.shiftCmd  = tick && (state == S_CMDH);
    strobe.diEn      = (state == S_CMDL) || (state == S_CMDH);
    strobe.shiftIn   = tick && (state == S_DATH);
    strobe.storeWord = tick && (state == S_DATH) && (bitCnt == DATA_LAST);
  end

  assign busy     = (state != S_IDLE);
  assign eeCs     = (state == S_SEL) || (state == S_CMDL) || (state == S_CMDH) ||
                    (state == S_DATL) || (state == S_DATH);
  assign eeSk     = (state == S_CMDH) || (state == S_DATH);
  assign wordAddr = ADDR_W'(wordIdx);
endmodule

// File: rtl/macload_dp.sv
module macload_dp
  import macload_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int WORDS     = 16,
  parameter int MAC_FIRST = 20,
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [ADDR_W-1:0]      wordAddr,
  input  logic                   eeDo,
  output logic                   eeDi,
  output logic [8*MAC_BYTES-1:0] macAddr
);
  localparam int CMD_BITS = OPC_W + ADDR_W;
  localparam int BPW      = DATA_W / 8;
  localparam int BYTES    = WORDS * BPW;
  localparam int BIDX_W   = $clog2(BYTES);

  logic [1:0]          doSync;
  logic [CMD_BITS-1:0] cmdSh;
  logic [DATA_W-1:0]   inSh;
  logic [DATA_W-1:0]   newWord;
  logic [7:0]          byteBuf [BYTES];

  assign newWord = {inSh[DATA_W-2:0], doSync[1]};
  assign eeDi    = strobe.diEn & cmdSh[CMD_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doSync <= '0;
      cmdSh  <= '0;
      inSh   <= '0;
    end else begin
      doSync <= {doSync[0], eeDo};
      if (strobe.loadCmd) begin
        cmdSh <= {READ_OPC, wordAddr};
      end else if (strobe.shiftCmd) begin
        cmdSh <= {cmdSh[CMD_BITS-2:0], 1'b0};
      end
      if (strobe.shiftIn) begin
        inSh <= newWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BYTES; b++) byteBuf[b] <= '0;
    end else if (strobe.storeWord) begin
      for (int k = 0; k < BPW; k++) begin
        byteBuf[BIDX_W'(int'(wordAddr) * BPW + k)] <= newWord[8*k +: 8];
      end
    end
  end

  for (genvar i = 0; i < MAC_BYTES; i++) begin : g_mac
    assign macAddr[8*(MAC_BYTES-i)-1 -: 8] = byteBuf[MAC_FIRST + i];
  end
endmodule

// File: rtl/eeprom_mac_loader.sv
module eeprom_mac_loader
  import macload_pkg::*;
#(
  parameter int HALF_DIV  = 64,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int WORDS     = 16,
  parameter int MAC_FIRST = 20,
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [8*MAC_BYTES-1:0] macAddr,
  output logic                   eeCs,
  output logic                   eeSk,
  output logic                   eeDi,
  input  logic                   eeDo
);
  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wordAddr;

  macload_ctrl #(
    .HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .eeCs(eeCs), .eeSk(eeSk), .strobe(strobe), .wordAddr(wordAddr)
  );

  macload_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .MAC_FIRST(MAC_FIRST), .MAC_BYTES(MAC_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordAddr(wordAddr),
    .eeDo(eeDo), .eeDi(eeDi), .macAddr(macAddr)
  );
endmodule

// File: rtl/eeprom_mac_loader_chk.sv
module eeprom_mac_loader_chk #(
  parameter int HALF_DIV  = 64,
  parameter int MAC_BYTES = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [8*MAC_BYTES-1:0] macAddr,
  input logic                   eeCs,
  input logic                   eeSk,
  input logic                   eeDi
);
  logic [31:0] skHiCnt;
  logic [31:0] csLoCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skHiCnt <= '0;
      csLoCnt <= '0;
    end else begin
      skHiCnt <= eeSk ? skHiCnt + 1 : '0;
      if (eeCs) csLoCnt <= '0;
      else if (csLoCnt != 32'hFFFF_FFFF) csLoCnt <= csLoCnt + 1;
    end
  end

  AST_SK_IN_CS:    assert property (@(posedge clk) disable iff (!rstN) eeSk |-> eeCs); // R10
  AST_DI_SETUP:    assert property (@(posedge clk) disable iff (!rstN) $rose(eeSk) |-> $stable(eeDi)); // R3
  AST_CS_GAP:      assert property (@(posedge clk) disable iff (!rstN) $rose(eeCs) |-> (csLoCnt >= 32'(HALF_DIV))); // R3
  AST_SK_HALF:     assert property (@(posedge clk) disable iff (!rstN) $fell(eeSk) |-> (skHiCnt == 32'(HALF_DIV))); // R7
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R8
  AST_MAC_HOLD:    assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> (done && $stable(macAddr))); // R8
  AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> (busy && !done)); // R2
endmodule

bind eeprom_mac_loader eeprom_mac_loader_chk #(
  .HALF_DIV(HALF_DIV), .MAC_BYTES(MAC_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .macAddr(macAddr), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi)
);

// File: tb/eeprom_mac_loader_bench.sv
module eeprom_mac_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int LOAD_LIMIT = 12000;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, eeCs, eeSk, eeDi;
  logic        eeDo = 1'b0;
  logic [47:0] macAddr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int patMode = 0;
  logic [31:0] epoch = 32'h0;

  // responder and monitor state
  logic        prevSk = 1'b0, prevCs = 1'b0, prevDone = 1'b0;
  int          edges = 0;
  logic [7:0]  cmdBits = '0;
  logic [5:0]  curAddr = '0;
  logic [3:0]  expAddr = '0;
  int          cmdBad = 0, wordsDone = 0, csFalls = 0, doneRises = 0;
  int          skRun = 0, skMin = 1000, skMax = 0;

  eeprom_mac_loader #(.HALF_DIV(HALF)) u_eeprom_mac_loader (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .macAddr(macAddr), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input int m, input logic [31:0] ep, input logic [5:0] a);
    case (m)
      1:       return 16'hFFFF;
      2:       return {2'b10, a, 2'b01, ~a};
      3:       return 16'h0000;
      default: return ep[15:0] ^ (16'(a) * 16'h3A5B) ^ {a, ep[25:16]};
    endcase
  endfunction

  function automatic logic [47:0] expMac(input int m, input logic [31:0] ep);
    logic [15:0] w10, w11, w12;
    w10 = pat(m, ep, 6'd10);
    w11 = pat(m, ep, 6'd11);
    w12 = pat(m, ep, 6'd12);
    return {w10[7:0], w10[15:8], w11[7:0], w11[15:8], w12[7:0], w12[15:8]};
  endfunction

  // behavioural EEPROM: checks commands, returns pattern words
  always @(posedge clk) begin
    prevSk   <= eeSk;
    prevCs   <= eeCs;
    prevDone <= done;
    if (done && !prevDone) doneRises <= doneRises + 1;
    if (prevCs && !eeCs) begin
      csFalls <= csFalls + 1;
      if (edges == 25) wordsDone <= wordsDone + 1;
      edges <= 0;
      eeDo  <= 1'b0;
    end else if (eeCs && eeSk && !prevSk) begin
      edges <= edges + 1;
      if (edges < 8) cmdBits <= {cmdBits[6:0], eeDi};
      if (edges == 8) begin
        // R3: command must be 1,1,0 then the expected address
        if ({cmdBits, eeDi} != {3'b110, 2'b00, expAddr}) cmdBad <= cmdBad + 1;
        curAddr <= {cmdBits[4:0], eeDi};
        expAddr <= expAddr + 1'b1;
      end
    end else if (eeCs && prevSk && !eeSk && edges >= 9 && edges <= 24) begin
      eeDo <= pat(patMode, epoch, curAddr)[15 - (edges - 9)]; // R4
    end
    // shift clock high width monitor (R7)
    if (eeSk) skRun <= skRun + 1;
    else begin
      if (prevSk) begin
        if (skRun < skMin) skMin <= skRun;
        if (skRun > skMax) skMax <= skRun;
      end
      skRun <= 0;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT) begin
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitDone(input string req);
    for (int i = 0; i < LOAD_LIMIT; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done === 1'b1, req, 64'(done), 64'd1);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic loadAndCheck(input string tag);
    int w0, c0, d0;
    w0 = wordsDone; c0 = csFalls; d0 = doneRises;
    pulseStart();
    check(busy === 1'b1 && done === 1'b0, {tag, " R2 busy/done after start"},
          64'({busy, done}), 64'b10);
    waitDone({tag, " R2 load completes"});
    @(negedge clk);
    check(macAddr === expMac(patMode, epoch), {tag, " R6 mac byte order"},
          64'(macAddr), 64'(expMac(patMode, epoch)));
    check(wordsDone - w0 == 16 && csFalls - c0 == 16, {tag, " R5 words and cs falls"},
          64'(wordsDone - w0), 64'd16);
    check(doneRises - d0 == 1, {tag, " R8 single done"}, 64'(doneRises - d0), 64'd1);
  endtask

  initial begin
    logic [47:0] held;
    void'($urandom(32'd20240611));
    // R1: reset values
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", 64'(busy), 0);
    check(done === 1'b0, "R1 done in reset", 64'(done), 0);
    check({eeCs, eeSk, eeDi} === 3'b000, "R1 eeprom pins in reset", 64'({eeCs, eeSk, eeDi}), 0);
    check(macAddr === 48'h0, "R1 mac in reset", 64'(macAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy === 1'b1, "R1 automatic load after reset", 64'(busy), 1);
    waitDone("R1 automatic load completes");
    @(negedge clk);
    check(macAddr === expMac(patMode, epoch), "R4 R6 mac after first load",
          64'(macAddr), 64'(expMac(patMode, epoch)));
    check(wordsDone == 16, "R5 words in first load", 64'(wordsDone), 16);
    check(csFalls == 16, "R5 cs falls in first load", 64'(csFalls), 16);
    check(cmdBad == 0, "R3 command bits", 64'(cmdBad), 0);
    // R8: hold
    held = macAddr;
    repeat (60) @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R8 done holds", 64'({done, busy}), 64'b10);
    check(macAddr === held, "R8 mac holds", 64'(macAddr), 64'(held));

    // random patterns
    for (int n = 0; n < 4; n++) begin
      epoch = $urandom;
      loadAndCheck("random");
    end
    // directed corners: all ones, distinct bytes, all zeros
    patMode = 1; loadAndCheck("ones");
    patMode = 2; loadAndCheck("distinct");
    patMode = 3; loadAndCheck("zeros");

    // R9: start while busy ignored
    begin
      int w0, d0;
      patMode = 0;
      epoch = $urandom;
      w0 = wordsDone; d0 = doneRises;
      pulseStart();
      repeat (300) @(negedge clk);
      check(busy === 1'b1, "R9 mid-load busy", 64'(busy), 1);
      pulseStart();
      repeat (700) @(negedge clk);
      pulseStart();
      waitDone("R9 load completes");
      repeat (500) @(negedge clk);
      check(busy === 1'b0, "R9 no extra load", 64'(busy), 0);
      check(wordsDone - w0 == 16, "R9 word count", 64'(wordsDone - w0), 16);
      check(doneRises - d0 == 1, "R9 done rises once", 64'(doneRises - d0), 1);
      check(macAddr === expMac(patMode, epoch), "R9 mac", 64'(macAddr), 64'(expMac(patMode, epoch)));
    end

    check(cmdBad == 0, "R3 R5 command order over all loads", 64'(cmdBad), 0);
    check(skMin == HALF && skMax == HALF, "R7 shift clock high width",
          64'({skMin[15:0], skMax[15:0]}), 64'({16'(HALF), 16'(HALF)}));
    check(eeSk === 1'b0 && eeCs === 1'b0, "R10 pins idle after load", 64'({eeSk, eeCs}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule